// File: doc/BRIEF.md
# Bus Lock Controller

This block drives the active-low bus lock signal of a processor bus interface and checks that the lock prefix is used legally. Each decoded instruction comes with a descriptor: a lock-prefix flag, a 4-bit class code, a memory-destination flag and the number of bus cycles its operand needs. The block decides whether the instruction faults, runs locked or needs no lock. The processor's own locked operations also arrive here, as one request line per kind: interrupt acknowledge, the task-descriptor busy-bit test-and-set, descriptor-table loads and page-table accessed/dirty updates.

A granted request becomes a locked sequence. The lock goes low first. One cycle later the block issues the first bus-cycle start strobe. It waits for the done handshake of each bus cycle and issues the next start, so the lock stays low for the whole operand, however it is aligned. The lock is released after the done handshake of the last cycle. Requests that arrive while a sequence runs wait in per-source pending slots. A fixed priority picks among the waiting slots. The sequencer has four states, named here with their transitions:

- SQ_IDLE goes to SQ_ARM (take) when a slot is pending. SQ_ARM goes to SQ_START (lead) unconditionally.
- SQ_START goes to SQ_WAIT (issued) unconditionally.
- SQ_WAIT goes to SQ_START (next_beat) on done while cycles remain. It goes to SQ_IDLE (release) on done of the last cycle. Otherwise it stays (hold).

Top module: `bus_lock_ctrl`

## Requirements
- R1: While reset is held and after it is released with no requests, `lock_n` is 1 and `bus_start`, `ud_fault` and `lock_active` are 0.
- R2: A prefixed instruction whose destination is in memory and whose class is 1 (bit test-and-modify), 2 (exchange), 3 (two-operand arithmetic/logic) or 4 (one-operand arithmetic/logic) runs as a locked sequence.
- R3: A prefixed instruction with a register destination, or with any class other than 1 to 4, raises `ud_fault` for exactly one cycle, in the cycle after the descriptor is sampled. The lock is not asserted for it and no bus cycle is started for it.
- R4: An unprefixed exchange (class 2) with a memory destination runs as a locked sequence.
- R5: An unprefixed instruction that is not a memory exchange causes no lock, no bus cycle and no fault.
- R6: `lock_n` falls in the cycle after a request is taken. `bus_start` is 0 in that cycle and first rises one cycle later.
- R7: A sequence issues exactly as many `bus_start` pulses as its cycle count, where a count of 0 counts as 1. Each pulse waits for the done of the previous bus cycle. `lock_n` stays low throughout and rises in the cycle right after the last done.
- R8: Each of the four implicit request lines (bit 0 interrupt acknowledge, bit 1 task busy bit, bit 2 descriptor load, bit 3 page A/D update) runs a locked sequence whose length is the `impl_beats` value sampled with the request.
- R9: Among pending requests, implicit bit 0 wins over bit 1, bit 1 over bit 2, bit 2 over bit 3, and bit 3 over an instruction request.
- R10: A request that arrives during a sequence is held. It starts after that sequence ends, with `lock_n` high for exactly one cycle between the two sequences.
- R11: `lock_active` is 1 exactly while `lock_n` is 0.
- R12: `bus_done` has no effect while no sequence is waiting for a bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_valid | input | 1 | Instruction descriptor valid, one cycle |
| insn_lock_pfx | input | 1 | Lock prefix present |
| insn_class | input | 4 | Instruction class code |
| insn_dst_mem | input | 1 | Destination operand is in memory |
| insn_beats | input | BEAT_W | Bus cycles for the operand |
| impl_req | input | NUM_IMPL | Implicit locked operation requests, one cycle each |
| impl_beats | input | BEAT_W | Bus cycles for an implicit request |
| bus_done | input | 1 | Current bus cycle finished |
| bus_start | output | 1 | Start one bus cycle |
| lock_n | output | 1 | Bus lock, active low |
| ud_fault | output | 1 | Undefined-opcode fault strobe |
| lock_active | output | 1 | A locked sequence is in progress |

## Verification
A descriptor sampled at edge k produces `ud_fault` after edge k. A locked request sampled at edge k drives `lock_n` low after edge k+1 and the first `bus_start` after edge k+2. A done sampled at edge m either starts the next bus cycle or releases the lock after edge m. The bench drives inputs and reads outputs only at falling edges. Its bus responder answers each start strobe with a done one cycle later, so every check falls on the cycle where its result is due. Back-to-back requests are checked for the single idle cycle between two sequences.

// File: rtl/bus_lock_pkg.sv
package bus_lock_pkg;

    // class codes of the instruction descriptor
    localparam logic [3:0] CLS_OTHER   = 4'd0;
    localparam logic [3:0] CLS_BITTEST = 4'd1;
    localparam logic [3:0] CLS_XCHG    = 4'd2;
    localparam logic [3:0] CLS_ALU2    = 4'd3;
    localparam logic [3:0] CLS_ALU1    = 4'd4;

    // implicit request slots, lower index has higher priority
    localparam int IMPL_INTA     = 0;
    localparam int IMPL_TASKBUSY = 1;
    localparam int IMPL_DESC     = 2;
    localparam int IMPL_PTE_AD   = 3;
    localparam int IMPL_KINDS    = 4;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ARM   = 2'd1,
        SQ_START = 2'd2,
        SQ_WAIT  = 2'd3
    } sq_state_e;

endpackage

// File: rtl/lk_decode.sv
module lk_decode
    import bus_lock_pkg::*;
(
    input  logic       valid,
    input  logic       pfx,
    input  logic [3:0] cls,
    input  logic       dst_mem,
    output logic       want_lock,
    output logic       fault
);

    logic listed;
    logic xchg_mem;

    always_comb begin
        unique case (cls)
            CLS_BITTEST, CLS_XCHG, CLS_ALU2, CLS_ALU1: listed = 1'b1;
            default:                                   listed = 1'b0;
        endcase
        xchg_mem  = (cls == CLS_XCHG) && dst_mem;
        fault     = valid && pfx && !(listed && dst_mem);
        want_lock = valid && !fault && (pfx || xchg_mem);
    end

endmodule

// File: rtl/lk_pend.sv
module lk_pend #(
    parameter int NIMPL = 4,
    parameter int BW    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             insn_req,
    input  logic [BW-1:0]    insn_beats,
    input  logic [NIMPL-1:0] impl_req,
    input  logic [BW-1:0]    impl_beats,
    input  logic             take,
    output logic             any_pend,
    output logic [BW-1:0]    sel_beats
);

    localparam int NS = NIMPL + 1;

    logic [NS-1:0] set_v;
    logic [BW-1:0] bin_v [NS];
    logic [NS-1:0] pend_q;
    logic [BW-1:0] beats_q [NS];
    logic [NS-1:0] gnt;

    for (genvar g = 0; g < NS; g++) begin : g_slot
        if (g < NIMPL) begin : g_impl
            assign set_v[g] = impl_req[g];
            assign bin_v[g] = impl_beats;
        end else begin : g_insn
            assign set_v[g] = insn_req;
            assign bin_v[g] = insn_beats;
        end
    end

    // fixed priority: lowest slot index first
    always_comb begin
        logic found;
        found = 1'b0;
        gnt   = '0;
        for (int i = 0; i < NS; i++) begin
            if (pend_q[i] && !found) begin
                gnt[i] = 1'b1;
                found  = 1'b1;
            end
        end
        sel_beats = '0;
        for (int i = 0; i < NS; i++) begin
            if (gnt[i]) sel_beats = beats_q[i];
        end
    end

    assign any_pend = |pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            for (int i = 0; i < NS; i++) beats_q[i] <= '0;
        end else begin
            for (int i = 0; i < NS; i++) begin
                if (set_v[i] && (!pend_q[i] || (take && gnt[i]))) begin
                    pend_q[i]  <= 1'b1;
                    beats_q[i] <= bin_v[i];
                end else if (take && gnt[i]) begin
                    pend_q[i] <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/lk_seq.sv
module lk_seq
    import bus_lock_pkg::*;
#(
    parameter int BW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          any_pend,
    input  logic [BW-1:0] pend_beats,
    input  logic          bus_done,
    output logic          take,
    output logic          lock_n,
    output logic          bus_start,
    output logic          active
);

    localparam logic [BW-1:0] ONE = BW'(1);

    sq_state_e     state_q, state_d;
    logic [BW-1:0] rem_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE:  if (any_pend) state_d = SQ_ARM;
            SQ_ARM:   state_d = SQ_START;
            SQ_START: state_d = SQ_WAIT;
            SQ_WAIT:  if (bus_done) state_d = (rem_q == ONE) ? SQ_IDLE : SQ_START;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            rem_q   <= ONE;
        end else begin
            state_q <= state_d;
            if (take) begin
                rem_q <= (pend_beats == '0) ? ONE : pend_beats;
            end else if (state_q == SQ_WAIT && bus_done && rem_q != ONE) begin
                rem_q <= rem_q - ONE;
            end
        end
    end

    always_comb begin
        take      = (state_q == SQ_IDLE) && any_pend;
        lock_n    = (state_q == SQ_IDLE);
        bus_start = (state_q == SQ_START);
        active    = (state_q != SQ_IDLE);
    end

endmodule

// File: rtl/bus_lock_ctrl.sv
module bus_lock_ctrl
    import bus_lock_pkg::*;
#(
    parameter int BEAT_W   = 4,
    parameter int NUM_IMPL = IMPL_KINDS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                insn_valid,
    input  logic                insn_lock_pfx,
    input  logic [3:0]          insn_class,
    input  logic                insn_dst_mem,
    input  logic [BEAT_W-1:0]   insn_beats,
    input  logic [NUM_IMPL-1:0] impl_req,
    input  logic [BEAT_W-1:0]   impl_beats,
    input  logic                bus_done,
    output logic                bus_start,
    output logic                lock_n,
    output logic                ud_fault,
    output logic                lock_active
);

    logic              want_lock;
    logic              bad_pfx;
    logic              take;
    logic              any_pend;
    logic [BEAT_W-1:0] sel_beats;

    lk_decode u_dec (
        .valid     (insn_valid),
        .pfx       (insn_lock_pfx),
        .cls       (insn_class),
        .dst_mem   (insn_dst_mem),
        .want_lock (want_lock),
        .fault     (bad_pfx)
    );

    lk_pend #(.NIMPL(NUM_IMPL), .BW(BEAT_W)) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .insn_req   (want_lock),
        .insn_beats (insn_beats),
        .impl_req   (impl_req),
        .impl_beats (impl_beats),
        .take       (take),
        .any_pend   (any_pend),
        .sel_beats  (sel_beats)
    );

    lk_seq #(.BW(BEAT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .any_pend   (any_pend),
        .pend_beats (sel_beats),
        .bus_done   (bus_done),
        .take       (take),
        .lock_n     (lock_n),
        .bus_start  (bus_start),
        .active     (lock_active)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) ud_fault <= 1'b0;
        else        ud_fault <= bad_pfx;
    end

endmodule

// File: rtl/bus_lock_chk.sv
module bus_lock_chk #(
    parameter int BEAT_W   = 4,
    parameter int NUM_IMPL = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                insn_valid,
    input logic                insn_lock_pfx,
    input logic [3:0]          insn_class,
    input logic                insn_dst_mem,
    input logic [BEAT_W-1:0]   insn_beats,
    input logic [NUM_IMPL-1:0] impl_req,
    input logic [BEAT_W-1:0]   impl_beats,
    input logic                bus_done,
    input logic                bus_start,
    input logic                lock_n,
    input logic                ud_fault,
    input logic                lock_active
);

    // R6: a start strobe is always preceded by a cycle of lock
    p_lead_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |-> (!lock_n && $past(!lock_n)));

    // R7: one start per bus cycle, next one only after a done
    p_single_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |=> !bus_start);

    // R7: lock released only right after a done
    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_n) |-> $past(bus_done));

    // R7: lock held while no done arrives
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_n && !bus_done) |=> !lock_n);

    // R3: a fault follows a prefixed descriptor
    p_fault_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ud_fault |-> $past(insn_valid && insn_lock_pfx));

    // R3: the fault is a single-cycle strobe unless a new descriptor came
    p_fault_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ud_fault && !insn_valid) |=> !ud_fault);

    // R11: status follows the lock pin
    p_active_r11: assert property (@(posedge clk) disable iff (!rst_n)
        lock_active != lock_n);

endmodule

bind bus_lock_ctrl bus_lock_chk #(.BEAT_W(BEAT_W), .NUM_IMPL(NUM_IMPL)) u_chk (.*);

// File: tb/bus_lock_ctrl_bench.sv
`timescale 1ns/1ps
module bus_lock_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       insn_valid = 1'b0;
    logic       insn_lock_pfx = 1'b0;
    logic [3:0] insn_class = 4'd0;
    logic       insn_dst_mem = 1'b0;
    logic [3:0] insn_beats = 4'd0;
    logic [3:0] impl_req = 4'd0;
    logic [3:0] impl_beats = 4'd0;
    logic       bus_done = 1'b0;
    logic       bus_start, lock_n, ud_fault, lock_active;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    bus_lock_ctrl u_bus_lock_ctrl (
        .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_lock_pfx(insn_lock_pfx),
        .insn_class(insn_class), .insn_dst_mem(insn_dst_mem), .insn_beats(insn_beats),
        .impl_req(impl_req), .impl_beats(impl_beats), .bus_done(bus_done),
        .bus_start(bus_start), .lock_n(lock_n), .ud_fault(ud_fault), .lock_active(lock_active)
    );

    // {pfx, class[3:0], mem, beats[3:0], exp_fault, exp_lock}
    localparam int NV = 12;
    localparam logic [11:0] VEC [NV] = '{
        {1'b1, 4'd1,  1'b1, 4'd1, 1'b0, 1'b1},
        {1'b1, 4'd2,  1'b1, 4'd2, 1'b0, 1'b1},
        {1'b1, 4'd3,  1'b1, 4'd4, 1'b0, 1'b1},
        {1'b1, 4'd4,  1'b1, 4'd0, 1'b0, 1'b1},
        {1'b1, 4'd0,  1'b1, 4'd2, 1'b1, 1'b0},
        {1'b1, 4'd3,  1'b0, 4'd2, 1'b1, 1'b0},
        {1'b1, 4'd9,  1'b1, 4'd2, 1'b1, 1'b0},
        {1'b0, 4'd2,  1'b1, 4'd2, 1'b0, 1'b1},
        {1'b0, 4'd3,  1'b1, 4'd2, 1'b0, 1'b0},
        {1'b0, 4'd2,  1'b0, 4'd2, 1'b0, 1'b0},
        {1'b1, 4'd2,  1'b0, 4'd1, 1'b1, 1'b0},
        {1'b1, 4'd15, 1'b1, 4'd3, 1'b1, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // waits for the lock, answers each start with a done one cycle later,
    // returns when the lock is released
    task automatic run_locked(input int exp_beats, input string req, output int wait_cyc);
        int  starts = 0;
        int  guard  = 0;
        bit  pend   = 1'b0;
        bit  last_done = 1'b0;
        wait_cyc = 0;
        @(negedge clk);
        while (lock_n && wait_cyc < 8) begin
            wait_cyc++;
            @(negedge clk);
        end
        chk(!lock_n, {req, " lock taken"}, int'(lock_n), 0);
        chk(!bus_start, "R6 no start in lead cycle", int'(bus_start), 0);
        chk(lock_active, "R11 status while locked", int'(lock_active), 1);
        while (!lock_n && guard < 200) begin
            bus_done  = pend;
            last_done = pend;
            pend      = 1'b0;
            if (bus_start) begin
                starts++;
                pend = 1'b1;
            end
            @(negedge clk);
            guard++;
        end
        bus_done = 1'b0;
        chk(starts == exp_beats, {req, " R7 start count"}, starts, exp_beats);
        chk(last_done, "R7 release right after last done", int'(last_done), 1);
        chk(!lock_active, "R11 status after release", int'(lock_active), 0);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int w, w2;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(lock_n && !bus_start && !ud_fault && !lock_active, "R1 in reset",
            {lock_n, bus_start, ud_fault, lock_active}, 4'b1000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(lock_n && !bus_start && !ud_fault && !lock_active, "R1 after reset",
            {lock_n, bus_start, ud_fault, lock_active}, 4'b1000);

        // vector table
        for (int i = 0; i < NV; i++) begin
            logic [11:0] v;
            string tag;
            int eb;
            v = VEC[i];
            tag = v[1] ? "R3" : (v[0] ? (v[11] ? "R2" : "R4") : "R5");
            eb = (v[5:2] == 4'd0) ? 1 : int'(v[5:2]);
            @(negedge clk);
            insn_valid = 1'b1; insn_lock_pfx = v[11]; insn_class = v[10:7];
            insn_dst_mem = v[6]; insn_beats = v[5:2];
            @(negedge clk);
            insn_valid = 1'b0;
            chk(ud_fault == v[1], {tag, " fault strobe"}, int'(ud_fault), int'(v[1]));
            chk(lock_n, {tag, " no lock yet"}, int'(lock_n), 1);
            if (v[0]) begin
                run_locked(eb, tag, w);
                chk(w == 0, "R6 lock one cycle after take", w, 0);
            end else begin
                bit seen = 1'b0;
                bit fl   = 1'b0;
                for (int k = 0; k < 5; k++) begin
                    @(negedge clk);
                    if (!lock_n || bus_start) seen = 1'b1;
                    if (ud_fault) fl = 1'b1;
                end
                chk(!seen, {tag, " no lock and no bus cycle"}, int'(seen), 0);
                chk(!fl, {tag, " fault lasts one cycle"}, int'(fl), 0);
            end
        end

        // R8: each implicit kind
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            impl_req = 4'(1 << k); impl_beats = 4'(k + 1);
            @(negedge clk);
            impl_req = 4'd0;
            run_locked(k + 1, "R8 implicit", w);
        end

        // R12: spurious done while idle
        @(negedge clk);
        bus_done = 1'b1;
        begin
            bit seen = 1'b0;
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                if (!lock_n || bus_start) seen = 1'b1;
            end
            bus_done = 1'b0;
            chk(!seen, "R12 done while idle ignored", int'(seen), 0);
        end

        // R9/R10: requests arriving during a running sequence
        @(negedge clk);
        insn_valid = 1'b1; insn_lock_pfx = 1'b1; insn_class = 4'd3;
        insn_dst_mem = 1'b1; insn_beats = 4'd4;
        @(negedge clk);
        insn_valid = 1'b0;
        fork
            run_locked(4, "R10 first", w);
            begin
                @(negedge clk);
                @(negedge clk);
                impl_req = 4'b1000; impl_beats = 4'd1;
                @(negedge clk);
                impl_req = 4'b0001; impl_beats = 4'd2;
                @(negedge clk);
                impl_req = 4'b0000;
                insn_valid = 1'b1; insn_lock_pfx = 1'b1; insn_class = 4'd4;
                insn_dst_mem = 1'b1; insn_beats = 4'd3;
                @(negedge clk);
                insn_valid = 1'b0;
            end
        join
        run_locked(2, "R9 slot0 first", w2);
        chk(w2 == 0, "R10 one idle cycle between sequences", w2, 0);
        run_locked(1, "R9 slot3 second", w2);
        chk(w2 == 0, "R10 one idle cycle between sequences", w2, 0);
        run_locked(3, "R9 instruction last", w2);
        chk(w2 == 0, "R10 one idle cycle between sequences", w2, 0);

        repeat (3) @(negedge clk);
        chk(lock_n && !bus_start, "R5 idle at end", int'(lock_n), 1);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule